// File: doc/BRIEF.md
# CEC Frame Receiver with Capped Message Buffer

This block listens to the single open-drain line of a consumer-electronics control bus and turns low-pulse timing into frames. A slow bit tick, one pulse per bus time unit (25 µs by default), drives every timer. The receiver first qualifies a start pulse by its low time and its full period. It then decodes each data bit by sampling the line at a fixed point after the falling edge. The header byte's destination nibble is compared with a programmable 4-bit logical address. For a matching frame the receiver pulls the line low during every acknowledge slot.

Received bytes land in a 16-byte buffer that is exposed as four 32-bit words. Byte k sits at bits 8k+7..8k, so the first byte is in the low byte of the first word. Bytes past the 16th are still acknowledged but are dropped. When the frame ends, cleanly or not, the block sets an end-of-message flag, a good flag and an interrupt. It then ignores the bus until software pulses a clear-receive input (high, then low). A synchronous receiver reset input returns the block to idle at any time.

Top module: `cec_frame_rx`

## Requirements
- R1: The logical address register resets to 4'hF (unregistered) and loads `addrIn` in a cycle where `addrWe` is high. While it is 4'hF, frames addressed to any destination other than 4'hF are ignored.
- R2: A start pulse is accepted only if its low time is within START_LOW_MIN..START_LOW_MAX ticks and its period is within START_PER_MIN..START_PER_MAX ticks (about 3.5–3.9 ms and 4.3–4.7 ms). With any other start pulse the frame that follows is not received and not acknowledged.
- R3: A data bit is 1 if the line is high SAMPLE_AT ticks (about 1.05 ms) after its falling edge, and 0 if it is still low. Each byte arrives most significant bit first.
- R4: If the header's low nibble (the destination) equals the logical address and is not 4'hF, `cecPullLow` is high for ACK_HOLD ticks (about 1.5 ms) from the start of every acknowledge slot. For destination 4'hF the frame is received but no slot is driven. For any other destination the frame is ignored: no interrupt and no drive.
- R5: Received byte k (with k below 16) appears on `rxData[8k+7:8k]`.
- R6: `rxCount` equals the number of stored bytes minus one.
- R7: At most 16 bytes, header included, are stored. Later bytes of the same frame are still acknowledged but leave the buffer and `rxCount` (15) unchanged.
- R8: After reset, `rxIrq`, `rxEom` and `rxGood` are low. After the acknowledge slot of the block whose end-of-message bit is 1, all three go high.
- R9: If a frame times out after more than BIT_PER_MAX ticks without an edge, or if a bit period is shorter than BIT_PER_MIN ticks, `rxIrq` and `rxEom` are set with `rxGood` low.
- R10: After an end of message, no frame is received or acknowledged and the buffer is held. This lasts until `clearRecv` has been high and then low again. `rxIrq` drops while `clearRecv` is high.
- R11: `swReset` returns the receiver to idle, clears `rxIrq`, `rxEom`, `rxGood` and the stored count, and releases the hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One-cycle pulse per bus time unit |
| cecIn | input | 1 | Synchronised bus line level |
| cecPullLow | output | 1 | Pull the bus line low (acknowledge) |
| addrWe | input | 1 | Load the logical address |
| addrIn | input | 4 | New logical address |
| clearRecv | input | 1 | Clear-receive handshake bit |
| swReset | input | 1 | Synchronous receiver reset |
| rxData | output | 128 | Byte buffer, byte k at bits 8k+7..8k |
| rxCount | output | 4 | Stored bytes minus one |
| rxEom | output | 1 | Frame ended |
| rxGood | output | 1 | Frame ended without error |
| rxIrq | output | 1 | Receive interrupt |

## Verification
The bench sweeps every registered logical address against a matching and a non-matching header, which catches a broken address compare or acknowledge driven on foreign frames. It measures the acknowledge pulse length, so a receiver that releases the line early or late is visible. Further tests send a frame longer than the buffer, where a missing cap would wrap and overwrite the header, and frames that stall or carry a short bit, which a careless design would report as good. Start pulses that are too short, too long or too slow would open a frame if the window check were wrong. A frame sent during the hold-off would be acknowledged or would overwrite the buffer if the clear handshake were skipped.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START_LOW,
    S_START_HIGH,
    S_BIT,
    S_HOLD
  } rxState_e;

  // Strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic frameStart;  // valid start seen: restart byte count
    logic bitValid;    // a data bit was sampled
    logic bitVal;      // its value
    logic byteDone;    // eighth bit of a byte
    logic frameEnd;    // end of message
    logic frameGood;   // qualifies frameEnd
    logic clrStatus;   // clear-receive seen during hold-off
  } rxStrobe_t;

endpackage

// File: rtl/cec_rx_ctrl.sv
module cec_rx_ctrl
  import cec_rx_pkg::*;
#(
  parameter int START_LOW_MIN = 140,
  parameter int START_LOW_MAX = 156,
  parameter int START_PER_MIN = 172,
  parameter int START_PER_MAX = 188,
  parameter int BIT_PER_MIN   = 82,
  parameter int BIT_PER_MAX   = 110,
  parameter int SAMPLE_AT     = 42,
  parameter int ACK_HOLD      = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       cecIn,
  input  logic       swReset,
  input  logic       clearRecv,
  input  logic [3:0] logicalAddr,
  input  logic [3:0] hdrDest,
  output rxStrobe_t  strb,
  output logic       cecPullLow
);

  localparam int CNT_W = $clog2(START_PER_MAX + 2);
  localparam logic [CNT_W-1:0] SL_MIN = CNT_W'(START_LOW_MIN);
  localparam logic [CNT_W-1:0] SL_MAX = CNT_W'(START_LOW_MAX);
  localparam logic [CNT_W-1:0] SP_MIN = CNT_W'(START_PER_MIN);
  localparam logic [CNT_W-1:0] SP_MAX = CNT_W'(START_PER_MAX);
  localparam logic [CNT_W-1:0] BP_MIN = CNT_W'(BIT_PER_MIN);
  localparam logic [CNT_W-1:0] BP_MAX = CNT_W'(BIT_PER_MAX);
  localparam logic [CNT_W-1:0] SMP    = CNT_W'(SAMPLE_AT);
  localparam logic [CNT_W-1:0] ACK_T  = CNT_W'(ACK_HOLD);
  localparam logic [3:0] EOM_IDX = 4'd8;
  localparam logic [3:0] ACK_IDX = 4'd9;

  rxState_e         state;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       bitIdx;
  logic             blkZero, lastBlk, ackEn, clrSeen, prevLine;
  logic             fallEdge, riseEdge, sampleNow, finalDone, destOk, ackDest;

  assign fallEdge  = prevLine & ~cecIn;
  assign riseEdge  = ~prevLine & cecIn;
  assign sampleNow = bitTick && (cnt == SMP);
  assign finalDone = (bitIdx == ACK_IDX) && lastBlk && (cnt >= BP_MIN);
  assign ackDest   = (hdrDest == logicalAddr) && (hdrDest != 4'hF);
  assign destOk    = ackDest || (hdrDest == 4'hF);

  assign cecPullLow = (state == S_BIT) && (bitIdx == ACK_IDX) && ackEn && (cnt < ACK_T);

  always_comb begin
    strb = '0;
    unique case (state)
      S_START_HIGH:
        strb.frameStart = fallEdge && (cnt >= SP_MIN) && (cnt <= SP_MAX);
      S_BIT: begin
        if (fallEdge) begin
          strb.frameEnd = (cnt < BP_MIN);
        end else if (finalDone) begin
          strb.frameEnd  = 1'b1;
          strb.frameGood = 1'b1;
        end else if (cnt > BP_MAX) begin
          strb.frameEnd = 1'b1;
        end else if (sampleNow && (bitIdx < EOM_IDX)) begin
          strb.bitValid = 1'b1;
          strb.bitVal   = cecIn;
          strb.byteDone = (bitIdx == 4'd7);
        end
      end
      S_HOLD:  strb.clrStatus = clearRecv;
      default: ;
    endcase
    if (swReset) strb = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      blkZero  <= 1'b0;
      lastBlk  <= 1'b0;
      ackEn    <= 1'b0;
      clrSeen  <= 1'b0;
      prevLine <= 1'b1;
    end else begin
      prevLine <= cecIn;
      if (bitTick && (cnt != '1)) cnt <= cnt + 1'b1;
      if (swReset) begin
        state   <= S_IDLE;
        cnt     <= '0;
        ackEn   <= 1'b0;
        clrSeen <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: if (fallEdge) begin
            state <= S_START_LOW;
            cnt   <= '0;
          end
          S_START_LOW: begin
            if (riseEdge) state <= ((cnt >= SL_MIN) && (cnt <= SL_MAX)) ? S_START_HIGH : S_IDLE;
            else if (cnt > SL_MAX) state <= S_IDLE;
          end
          S_START_HIGH: begin
            if (fallEdge) begin
              cnt <= '0;
              if ((cnt >= SP_MIN) && (cnt <= SP_MAX)) begin
                state   <= S_BIT;
                bitIdx  <= '0;
                blkZero <= 1'b1;
                lastBlk <= 1'b0;
                ackEn   <= 1'b0;
              end else begin
                state <= S_START_LOW;
              end
            end else if (cnt > SP_MAX) begin
              state <= S_IDLE;
            end
          end
          S_BIT: begin
            if (fallEdge) begin
              cnt <= '0;
              if (cnt < BP_MIN) begin
                state   <= S_HOLD;
                clrSeen <= 1'b0;
              end else if (bitIdx == ACK_IDX) begin
                bitIdx  <= '0;
                blkZero <= 1'b0;
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end else if (finalDone || (cnt > BP_MAX)) begin
              state   <= S_HOLD;
              clrSeen <= 1'b0;
            end else if (sampleNow && (bitIdx == EOM_IDX)) begin
              lastBlk <= cecIn;
              if (blkZero) begin
                ackEn <= ackDest;
                if (!destOk) state <= S_IDLE;
              end
            end
          end
          S_HOLD: begin
            if (clearRecv) clrSeen <= 1'b1;
            else if (clrSeen) begin
              state   <= S_IDLE;
              clrSeen <= 1'b0;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cec_rx_dpath.sv
module cec_rx_dpath
  import cec_rx_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   swReset,
  input  rxStrobe_t                              strb,
  input  logic                                   addrWe,
  input  logic [3:0]                             addrIn,
  output logic [3:0]                             logicalAddr,
  output logic [3:0]                             hdrDest,
  output logic [NUM_WORDS*WORD_W-1:0]            rxData,
  output logic [$clog2(NUM_WORDS*WORD_W/8)-1:0]  rxCount,
  output logic                                   rxEom,
  output logic                                   rxGood,
  output logic                                   rxIrq
);

  localparam int BUF_BYTES = NUM_WORDS * WORD_W / 8;
  localparam int SC_W      = $clog2(BUF_BYTES + 1);
  localparam int CO_W      = $clog2(BUF_BYTES);

  logic [7:0]      shiftReg, nextByte;
  logic [SC_W-1:0] storedCnt;

  assign nextByte = {shiftReg[6:0], strb.bitVal};
  assign hdrDest  = shiftReg[3:0];
  assign rxCount  = (storedCnt == '0) ? '0 : CO_W'(storedCnt - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) logicalAddr <= 4'hF;
    else if (addrWe) logicalAddr <= addrIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      storedCnt <= '0;
      rxEom     <= 1'b0;
      rxGood    <= 1'b0;
      rxIrq     <= 1'b0;
    end else if (swReset) begin
      shiftReg  <= '0;
      storedCnt <= '0;
      rxEom     <= 1'b0;
      rxGood    <= 1'b0;
      rxIrq     <= 1'b0;
    end else begin
      if (strb.bitValid) shiftReg <= nextByte;
      if (strb.frameStart) begin
        storedCnt <= '0;
        rxEom     <= 1'b0;
        rxGood    <= 1'b0;
      end else if (strb.byteDone && (storedCnt != SC_W'(BUF_BYTES))) begin
        storedCnt <= storedCnt + 1'b1;
      end
      if (strb.frameEnd) begin
        rxEom  <= 1'b1;
        rxGood <= strb.frameGood;
        rxIrq  <= 1'b1;
      end else if (strb.clrStatus) begin
        rxIrq <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_slot
    logic [7:0] slot;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slot <= '0;
      else if (swReset) slot <= '0;
      else if (strb.byteDone && (storedCnt == SC_W'(g))) slot <= nextByte;
    end
    assign rxData[g*8 +: 8] = slot;
  end

endmodule

// File: rtl/cec_frame_rx.sv
module cec_frame_rx
  import cec_rx_pkg::*;
#(
  parameter int NUM_WORDS     = 4,
  parameter int WORD_W        = 32,
  parameter int START_LOW_MIN = 140,
  parameter int START_LOW_MAX = 156,
  parameter int START_PER_MIN = 172,
  parameter int START_PER_MAX = 188,
  parameter int BIT_PER_MIN   = 82,
  parameter int BIT_PER_MAX   = 110,
  parameter int SAMPLE_AT     = 42,
  parameter int ACK_HOLD      = 60
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  bitTick,
  input  logic                                  cecIn,
  output logic                                  cecPullLow,
  input  logic                                  addrWe,
  input  logic [3:0]                            addrIn,
  input  logic                                  clearRecv,
  input  logic                                  swReset,
  output logic [NUM_WORDS*WORD_W-1:0]           rxData,
  output logic [$clog2(NUM_WORDS*WORD_W/8)-1:0] rxCount,
  output logic                                  rxEom,
  output logic                                  rxGood,
  output logic                                  rxIrq
);

  rxStrobe_t  strb;
  logic [3:0] logicalAddr, hdrDest;

  cec_rx_ctrl #(
    .START_LOW_MIN(START_LOW_MIN), .START_LOW_MAX(START_LOW_MAX),
    .START_PER_MIN(START_PER_MIN), .START_PER_MAX(START_PER_MAX),
    .BIT_PER_MIN(BIT_PER_MIN),     .BIT_PER_MAX(BIT_PER_MAX),
    .SAMPLE_AT(SAMPLE_AT),         .ACK_HOLD(ACK_HOLD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .cecIn(cecIn),
    .swReset(swReset), .clearRecv(clearRecv),
    .logicalAddr(logicalAddr), .hdrDest(hdrDest),
    .strb(strb), .cecPullLow(cecPullLow)
  );

  cec_rx_dpath #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .swReset(swReset), .strb(strb),
    .addrWe(addrWe), .addrIn(addrIn),
    .logicalAddr(logicalAddr), .hdrDest(hdrDest),
    .rxData(rxData), .rxCount(rxCount),
    .rxEom(rxEom), .rxGood(rxGood), .rxIrq(rxIrq)
  );

endmodule

// File: rtl/cec_frame_rx_chk.sv
module cec_frame_rx_chk (
  input logic clk,
  input logic rstN,
  input logic swReset,
  input logic clearRecv,
  input logic cecPullLow,
  input logic rxEom,
  input logic rxGood,
  input logic rxIrq
);

  AST_NO_ACK_WHILE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    cecPullLow |-> !rxIrq); // R10

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rxIrq && !clearRecv && !swReset) |=> rxIrq); // R10

  AST_GOOD_NEEDS_EOM: assert property (@(posedge clk) disable iff (!rstN)
    rxGood |-> rxEom); // R8

  AST_IRQ_WITH_EOM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIrq) |-> rxEom); // R8

  AST_SWRESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (!rxIrq && !rxEom && !cecPullLow)); // R11

endmodule

bind cec_frame_rx cec_frame_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .swReset(swReset), .clearRecv(clearRecv),
  .cecPullLow(cecPullLow), .rxEom(rxEom), .rxGood(rxGood), .rxIrq(rxIrq)
);

// File: tb/sim_cec_frame_rx.sv
module sim_cec_frame_rx;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic clk = 1'b0, rstN = 1'b0, bitTick = 1'b1, initLow = 1'b0;
  logic addrWe = 1'b0, clearRecv = 1'b0, swReset = 1'b0;
  logic [3:0] addrIn = '0;
  logic cecPullLow, rxEom, rxGood, rxIrq;
  logic [127:0] rxData;
  logic [3:0] rxCount;
  wire cecLine = ~(initLow | cecPullLow);

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;
  int lastAcks, lastMaxPull;
  logic [7:0] msg [20];

  always #(CLK_PERIOD/2) clk = ~clk;

  cec_frame_rx u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .cecIn(cecLine),
    .cecPullLow(cecPullLow), .addrWe(addrWe), .addrIn(addrIn),
    .clearRecv(clearRecv), .swReset(swReset), .rxData(rxData),
    .rxCount(rxCount), .rxEom(rxEom), .rxGood(rxGood), .rxIrq(rxIrq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int lowT, input int perT, output int pc, output bit lowMid);
    pc = 0; lowMid = 1'b0;
    for (int i = 0; i < perT; i++) begin
      initLow = (i < lowT);
      @(negedge clk);
      if (cecPullLow) pc++;
      if (i == 45) lowMid = !cecLine;
    end
    initLow = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit eom, output int pc, output bit acked);
    int dpc; bit dlow;
    for (int k = 7; k >= 0; k--) pulse(b[k] ? 24 : 60, 96, dpc, dlow);
    pulse(eom ? 24 : 60, 96, dpc, dlow);
    pulse(24, 96, pc, acked);
  endtask

  task automatic sendFrameS(input int lowT, input int perT, input int n);
    int pc; bit ak, dl;
    lastAcks = 0; lastMaxPull = 0;
    pulse(lowT, perT, pc, dl);
    for (int b = 0; b < n; b++) begin
      sendByte(msg[b], b == n - 1, pc, ak);
      if (ak) lastAcks++;
      if (pc > lastMaxPull) lastMaxPull = pc;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic sendFrame(input int n);
    sendFrameS(148, 180, n);
  endtask

  task automatic clearHandshake();
    clearRecv = 1'b1;
    repeat (2) @(negedge clk);
    check(rxIrq == 1'b0, "R10 irq dropped by clear", rxIrq, 0);
    clearRecv = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic setAddr(input logic [3:0] a);
    addrIn = a; addrWe = 1'b1;
    @(negedge clk);
    addrWe = 1'b0;
  endtask

  task automatic checkBytes(input int n, input string req);
    int m = (n > 16) ? 16 : n;
    for (int k = 0; k < m; k++)
      check(rxData[8*k +: 8] == msg[k], req, rxData[8*k +: 8], msg[k]);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int pc; bit ak, dl;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(rxIrq == 0 && rxEom == 0 && rxGood == 0, "R8 reset flags", {rxIrq, rxEom, rxGood}, 0);
    check(rxCount == 0 && cecPullLow == 0, "R6 reset count/drive", {rxCount, cecPullLow}, 0);

    // R1 unregistered address: directed frame ignored
    msg[0] = 8'h43; msg[1] = 8'h5A;
    sendFrame(2);
    check(rxIrq == 0, "R1 unregistered ignores dest 3", rxIrq, 0);
    check(lastAcks == 0, "R1 no ack when unregistered", lastAcks, 0);

    // R4 broadcast accepted but not acknowledged
    msg[0] = 8'h4F; msg[1] = 8'h36;
    sendFrame(2);
    check(rxIrq && rxEom && rxGood, "R8 broadcast end flags", {rxIrq, rxEom, rxGood}, 7);
    check(lastAcks == 0 && lastMaxPull == 0, "R4 broadcast not acked", lastMaxPull, 0);
    checkBytes(2, "R5 broadcast bytes");
    check(rxCount == 1, "R6 two bytes", rxCount, 1);
    clearHandshake();

    // Sweep of every registered address: match and mismatch
    for (int a = 0; a < 15; a++) begin
      setAddr(4'(a));
      msg[0] = {4'(15 - a), 4'(a)};
      msg[1] = {4'(a), ~4'(a)};
      sendFrame(2);
      check(rxIrq && rxGood, "R8 addressed frame good", {rxIrq, rxGood}, 3);
      check(lastAcks == 2, "R4 both slots acked", lastAcks, 2);
      check(lastMaxPull >= 58 && lastMaxPull <= 62, "R4 ack length", lastMaxPull, 60);
      checkBytes(2, "R3 R5 bytes MSB first");
      check(rxCount == 1, "R6 count", rxCount, 1);
      clearHandshake();
      msg[0] = {4'h0, 4'((a + 1) % 15)};
      sendFrame(1);
      check(rxIrq == 0 && lastAcks == 0, "R4 foreign dest ignored", {rxIrq, 4'(lastAcks)}, 0);
    end

    // R3 fixed pattern, R6 five bytes
    setAddr(4'h2);
    msg[0] = 8'h12; msg[1] = 8'hA5; msg[2] = 8'h01; msg[3] = 8'h80; msg[4] = 8'hFF;
    sendFrame(5);
    check(rxData[15:8] == 8'hA5, "R3 byte A5", rxData[15:8], 8'hA5);
    checkBytes(5, "R5 five bytes");
    check(rxCount == 4, "R6 five bytes count", rxCount, 4);
    clearHandshake();

    // R7 overlong frame
    msg[0] = 8'h12;
    for (int k = 1; k < 18; k++) msg[k] = 8'(k * 13 + 7);
    sendFrame(18);
    check(rxCount == 15, "R7 count capped", rxCount, 15);
    check(lastAcks == 18, "R7 extra bytes acked", lastAcks, 18);
    checkBytes(18, "R7 first 16 kept");
    check(rxGood == 1, "R7 good", rxGood, 1);
    clearHandshake();

    // R2 bad start pulses
    msg[0] = 8'h12; msg[1] = 8'h77;
    sendFrameS(120, 180, 2);
    check(rxIrq == 0 && lastAcks == 0, "R2 short start ignored", rxIrq, 0);
    sendFrameS(170, 180, 2);
    check(rxIrq == 0 && lastAcks == 0, "R2 long start ignored", rxIrq, 0);
    sendFrameS(148, 200, 2);
    check(rxIrq == 0 && lastAcks == 0, "R2 slow start ignored", rxIrq, 0);
    sendFrameS(152, 184, 2);
    check(rxIrq == 1 && lastAcks == 2, "R2 in-window start taken", rxIrq, 1);
    clearHandshake();

    // R9 timeout mid-frame
    pulse(148, 180, pc, dl);
    sendByte(8'h12, 1'b0, pc, ak);
    for (int k = 0; k < 3; k++) pulse(24, 96, pc, dl);
    repeat (200) @(negedge clk);
    check(rxIrq && rxEom && !rxGood, "R9 timeout flags", {rxIrq, rxEom, rxGood}, 6);
    check(rxCount == 0 && rxData[7:0] == 8'h12, "R9 header kept", rxData[7:0], 8'h12);
    clearHandshake();

    // R9 short bit period
    pulse(148, 180, pc, dl);
    sendByte(8'h12, 1'b0, pc, ak);
    pulse(24, 50, pc, dl);
    pulse(24, 96, pc, dl);
    repeat (20) @(negedge clk);
    check(rxIrq && !rxGood, "R9 short period flags", {rxIrq, rxGood}, 2);
    clearHandshake();

    // R10 hold-off
    msg[0] = 8'h12; msg[1] = 8'h11;
    sendFrame(2);
    check(rxIrq == 1, "R10 frame A done", rxIrq, 1);
    msg[1] = 8'h22;
    sendFrame(2);
    check(lastMaxPull == 0, "R10 no ack while held", lastMaxPull, 0);
    check(rxData[15:8] == 8'h11 && rxIrq, "R10 buffer held", rxData[15:8], 8'h11);
    clearHandshake();
    sendFrame(2);
    check(rxData[15:8] == 8'h22 && rxIrq, "R10 accepted after clear", rxData[15:8], 8'h22);

    // R11 software reset during hold-off and mid-frame
    swReset = 1'b1; @(negedge clk); swReset = 1'b0;
    check(!rxIrq && !rxEom && !rxGood, "R11 flags cleared", {rxIrq, rxEom, rxGood}, 0);
    pulse(148, 180, pc, dl);
    sendByte(8'h12, 1'b0, pc, ak);
    swReset = 1'b1; @(negedge clk); swReset = 1'b0;
    sendByte(8'h44, 1'b1, pc, ak);
    repeat (200) @(negedge clk);
    check(!rxIrq && rxCount == 0 && !ak, "R11 frame abandoned", {rxIrq, rxCount}, 0);
    msg[1] = 8'h9C;
    sendFrame(2);
    check(rxIrq && rxGood && rxData[15:8] == 8'h9C, "R11 idle after reset", rxData[15:8], 8'h9C);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule